// File: doc/BRIEF.md
# Condition Skip and Repeat Sequencer

This block is the front-end control for a processor that has no conditional branches. It reads the instruction now being issued and tests a 4-bit condition code, taken from instruction bits 11:8, against the W register's sign and zero status and the carry and overflow flags. It then does one of three things with the result. A skip instruction whose condition holds cancels the next issued instruction. The core turns the cancelled instruction into a NOP. A set-on-condition instruction gets a flag word that is either all ones or all zeros. A repeat instruction holds instruction fetch, so the next instruction is issued again for a counted number of executions. The count comes either from a 5-bit immediate or from the low bits of W.

The core presents one instruction word per cycle with `instr_valid`. The sequencer's outputs for that word are combinational in the same cycle: `kill_next`, `hold_fetch`, `cond_true`, `set_stb`, `flag_word` and `drop_req`. Pending state lives in two registers, which update at the clock edge that ends an issue cycle: a kill request, and the repeat counter. A skip cancels exactly one word, so a skip must not be followed by a two-word instruction.

Top module: `cs_sequencer`

## Requirements
- R1: The condition code is `instr[11:8]`. Code 0000 is never true and code 0001 is always true, whatever the flags.
- R2: Unsigned codes. 0100 is true when carry is set, and 0101 when carry is clear. 0010 is true when W is zero or carry is clear. 0011 is true when W is nonzero and carry is set.
- R3: Status codes. 0110 is true when W is zero, and 0111 when W is nonzero. 1000 is true when overflow is set, and 1001 when it is clear. 1010 is true when W is negative, and 1011 when W is non-negative.
- R4: Signed codes, where s is the W sign XOR overflow. 1100 is true when s is 1, and 1101 when s is 0. 1110 is true when W is zero or s is 1. 1111 is true when W is nonzero and s is 0.
- R5: A skip is `instr[15:12]=0000` with `instr[7:0]=0x00` or `0x20`. When a skip issues and its condition holds, `kill_next` is high in the cycle of the next valid instruction only. Invalid cycles in between do not use up the pending kill.
- R6: A killed instruction has no effect. It arms no skip, loads no repeat, raises no `set_stb` or `drop_req`, and leaves `flag_word` at zero.
- R7: The skip form with `instr[7:0]=0x20` raises `drop_req` in its own issue cycle, whether or not its condition holds.
- R8: A set-on-condition is `instr[15:12]=0000` with `instr[2:0]=011`. It raises `set_stb`, and `flag_word` is 16 ones when the condition holds and 16 zeros otherwise. Outside a set-on-condition, `flag_word` is zero.
- R9: A repeat is `instr[15:8]=0x71` with `instr[7:5]=000`, and carries n in `instr[4:0]`. The next instruction is then executed n+1 times (1 to 32). `hold_fetch` is high on each of its issues except the last.
- R10: The repeat form `instr[15:8]=0x71` with `instr[7:0]=0x20` takes n from `w_count`. It otherwise behaves as R9.
- R11: While a repeat is active, skip and repeat instructions are ignored. They raise no kill, no drop and no new count.
- R12: During and right after reset, no kill is pending and no repeat is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction word is issued this cycle |
| instr | input | 16 | Issued instruction word |
| w_neg | input | 1 | W register sign bit |
| w_zero | input | 1 | W register equals zero |
| carry | input | 1 | Carry flag |
| ovf | input | 1 | Overflow flag |
| w_count | input | 5 | Low bits of W, used as the repeat count for the W form |
| kill_next | output | 1 | The word issued this cycle is cancelled (turn into NOP) |
| hold_fetch | output | 1 | Keep the fetch address; re-issue the same word next |
| cond_true | output | 1 | Condition `instr[11:8]` holds for the current flags |
| set_stb | output | 1 | Set-on-condition issued and not killed |
| flag_word | output | 16 | All-ones or all-zeros result of a set-on-condition |
| drop_req | output | 1 | Pop the data stack (skip-with-drop form) |

## Verification
The assertions assume that the core re-presents the same word while `hold_fetch` is high. They also assume that a repeat's target is not itself a two-word instruction. The stimulus keeps to these rules: the bench re-issues the same word while `hold_fetch` is high, and it only ever places one-word instructions after skips and repeats. The flag inputs are swept over all 16 combinations, including the physically impossible one where W is both negative and zero. The condition equations are defined for every input pattern, so that case needs no assumption.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic [2:0] {
    OP_OTHER,
    OP_SKIP,
    OP_SKIPDROP,
    OP_SETC,
    OP_REPI,
    OP_REPW
  } op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } flags_t;

  // Each odd code is the complement of the even code just below it.
  function automatic logic cond_holds(input logic [3:0] code, input flags_t f);
    logic sv;
    logic base;
    sv = f.neg ^ f.ovf;
    case (code[3:1])
      3'd0:    base = 1'b0;
      3'd1:    base = f.zero | ~f.carry;
      3'd2:    base = f.carry;
      3'd3:    base = f.zero;
      3'd4:    base = f.ovf;
      3'd5:    base = f.neg;
      3'd6:    base = sv;
      default: base = f.zero | sv;
    endcase
    return base ^ code[0];
  endfunction

endpackage

// File: rtl/cs_decode.sv
module cs_decode
  import cs_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instr,
  output op_e                op
);
  localparam int TOP = INSTR_W - 1;

  logic grp_ctl;
  logic grp_rep;

  assign grp_ctl = (instr[TOP -: 4] == 4'h0);
  assign grp_rep = (instr[TOP -: 8] == 8'h71);

  always_comb begin
    op = OP_OTHER;
    if (grp_ctl) begin
      if (instr[7:0] == 8'h00)       op = OP_SKIP;
      else if (instr[7:0] == 8'h20)  op = OP_SKIPDROP;
      else if (instr[2:0] == 3'b011) op = OP_SETC;
    end else if (grp_rep) begin
      if (instr[7:5] == 3'b000)      op = OP_REPI;
      else if (instr[7:0] == 8'h20)  op = OP_REPW;
    end
  end
endmodule

// File: rtl/cs_cond_eval.sv
module cs_cond_eval
  import cs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        code,
  input  flags_t            flags,
  input  logic              set_stb,
  output logic              cond,
  output logic [DATA_W-1:0] flag_word
);
  assign cond = cond_holds(code, flags);

  for (genvar i = 0; i < DATA_W; i++) begin : g_fill
    assign flag_word[i] = set_stb & cond;
  end
endmodule

// File: rtl/cs_skip_ctl.sv
module cs_skip_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_valid,
  input  logic arm,
  output logic kill_pend,
  output logic kill_next
);
  assign kill_next = kill_pend & instr_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)          kill_pend <= 1'b0;
    else if (kill_next)  kill_pend <= 1'b0;
    else if (arm)        kill_pend <= 1'b1;
  end

  AST_KILL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    kill_next |=> !kill_next);  // R5
  AST_ARM_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> kill_pend);  // R5
endmodule

// File: rtl/cs_repeat_ctr.sv
module cs_repeat_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic             hold
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic last;
  assign last = (cnt == ZERO);
  assign hold = step & ~last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= ZERO;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= load_val;
    end else if (step) begin
      if (last) active <= 1'b0;
      else      cnt    <= cnt - 1'b1;
    end
  end

  AST_REP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (active && cnt == CNT_W'($past(cnt) - 1'b1)));  // R9
  AST_REP_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !load) |=> !active);  // R9
  AST_REP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active && cnt == $past(load_val)));  // R10
endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
  import cs_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic              w_neg,
  input  logic              w_zero,
  input  logic              carry,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  w_count,
  output logic              kill_next,
  output logic              hold_fetch,
  output logic              cond_true,
  output logic              set_stb,
  output logic [DATA_W-1:0] flag_word,
  output logic              drop_req
);
  op_e              op;
  flags_t           flags;
  logic             kill_pend;
  logic             live;
  logic             ctrl_ok;
  logic             is_skip;
  logic             is_rep;
  logic             skip_arm;
  logic             rep_load;
  logic             rep_step;
  logic             rep_active;
  logic [CNT_W-1:0] rep_cnt;
  logic [CNT_W-1:0] rep_val;

  assign flags = '{neg: w_neg, zero: w_zero, carry: carry, ovf: ovf};

  cs_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr (instr),
    .op    (op)
  );

  // A killed word is dead; control words are also ignored inside a repeat.
  assign live     = instr_valid & ~kill_pend;
  assign ctrl_ok  = live & ~rep_active;
  assign is_skip  = (op == OP_SKIP) | (op == OP_SKIPDROP);
  assign is_rep   = (op == OP_REPI) | (op == OP_REPW);
  assign skip_arm = ctrl_ok & is_skip & cond_true;
  assign drop_req = ctrl_ok & (op == OP_SKIPDROP);
  assign set_stb  = live & (op == OP_SETC);
  assign rep_load = ctrl_ok & is_rep;
  assign rep_step = live & rep_active;
  assign rep_val  = (op == OP_REPI) ? instr[CNT_W-1:0] : w_count;

  cs_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .code      (instr[11:8]),
    .flags     (flags),
    .set_stb   (set_stb),
    .cond      (cond_true),
    .flag_word (flag_word)
  );

  cs_skip_ctl u_skip (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .arm         (skip_arm),
    .kill_pend   (kill_pend),
    .kill_next   (kill_next)
  );

  cs_repeat_ctr #(.CNT_W(CNT_W)) u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rep_load),
    .load_val (rep_val),
    .step     (rep_step),
    .active   (rep_active),
    .cnt      (rep_cnt),
    .hold     (hold_fetch)
  );

  AST_NO_KILL_IN_REP: assert property (@(posedge clk) disable iff (!rst_n)
    rep_active |-> !kill_pend);  // R11
  AST_FLAG_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |-> ($countones(flag_word) == 0 || $countones(flag_word) == DATA_W));  // R8
  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !set_stb |-> (flag_word == '0));  // R8
  AST_KILLED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    kill_next |-> (!drop_req && !set_stb && !hold_fetch));  // R6
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fetch |-> (instr_valid && rep_active));  // R9
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (!kill_pend && !rep_active));  // R12
endmodule

// File: tb/sim_cs_sequencer.sv
`timescale 1ns/1ps
module sim_cs_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        w_neg = 1'b0, w_zero = 1'b0, carry = 1'b0, ovf = 1'b0;
  logic [4:0]  w_count = 5'd0;
  logic        kill_next, hold_fetch, cond_true, set_stb, drop_req;
  logic [15:0] flag_word;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cs_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .w_neg(w_neg), .w_zero(w_zero), .carry(carry), .ovf(ovf),
    .w_count(w_count), .kill_next(kill_next), .hold_fetch(hold_fetch),
    .cond_true(cond_true), .set_stb(set_stb), .flag_word(flag_word),
    .drop_req(drop_req)
  );

  localparam logic [15:0] PLAIN = 16'h4000;

  function automatic bit model_cond(input int code, input bit n, input bit z,
                                    input bit c, input bit v);
    case (code)
      0:  return 0;
      1:  return 1;
      2:  return z || !c;
      3:  return !z && c;
      4:  return c;
      5:  return !c;
      6:  return z;
      7:  return !z;
      8:  return v;
      9:  return !v;
      10: return n;
      11: return !n;
      12: return n != v;
      13: return n == v;
      14: return z || (n != v);
      default: return !z && (n == v);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic v);
    @(negedge clk);
    instr = w;
    instr_valid = v;
    #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  // Runs a repeat and returns how many times the next word was executed.
  task automatic run_repeat(input logic [15:0] rep_word, output int execs);
    issue(rep_word, 1'b1);
    execs = 0;
    for (int k = 0; k < 40; k++) begin
      issue(PLAIN, 1'b1);
      execs++;
      if (!hold_fetch) break;
    end
  endtask

  initial begin
    #150000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int execs;
    bit exp;
    string tag;

    // R12: reset state, with a live word presented
    @(negedge clk);
    instr = PLAIN; instr_valid = 1'b1; #1;
    chk("R12 kill in reset", kill_next, 0);
    chk("R12 hold in reset", hold_fetch, 0);
    do_reset();
    issue(PLAIN, 1'b1);
    chk("R12 kill after reset", kill_next, 0);
    chk("R12 hold after reset", hold_fetch, 0);

    // R1-R4 and R8: full sweep of codes and flag patterns via set-on-condition
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        @(negedge clk);
        {w_neg, w_zero, carry, ovf} = f[3:0];
        instr = {4'h0, code[3:0], 8'h03};
        instr_valid = 1'b1;
        #1;
        exp = model_cond(code, f[3], f[2], f[1], f[0]);
        if (code < 2)       tag = "R1";
        else if (code < 6)  tag = (code < 4) ? "R2" : "R2 carry";
        else if (code < 12) tag = "R3";
        else                tag = "R4";
        chk(tag, cond_true, exp);
        chk("R8 flag word", flag_word, exp ? 32'h0000FFFF : 32'h0);
        chk("R8 strobe", set_stb, 1);
      end
    end
    issue(PLAIN, 1'b1);
    chk("R8 idle flag word", flag_word, 0);
    chk("R8 idle strobe", set_stb, 0);

    // R5: skip-always kills exactly the next word
    {w_neg, w_zero, carry, ovf} = 4'b0000;
    issue(16'h0100, 1'b1);
    chk("R5 skip own cycle", kill_next, 0);
    issue(PLAIN, 1'b1);
    chk("R5 next killed", kill_next, 1);
    issue(PLAIN, 1'b1);
    chk("R5 one word only", kill_next, 0);
    // skip-never: nothing killed
    issue(16'h0000, 1'b1);
    issue(PLAIN, 1'b1);
    chk("R5 never skip", kill_next, 0);
    // pending kill survives invalid cycles
    issue(16'h0100, 1'b1);
    issue(PLAIN, 1'b0);
    chk("R5 idle not killed", kill_next, 0);
    issue(PLAIN, 1'b0);
    issue(PLAIN, 1'b1);
    chk("R5 kill after gap", kill_next, 1);
    // condition-dependent skip: EQ with W zero kills, with W nonzero does not
    w_zero = 1'b1;
    issue(16'h0600, 1'b1);
    issue(PLAIN, 1'b1);
    chk("R5 EQ true", kill_next, 1);
    w_zero = 1'b0;
    issue(16'h0600, 1'b1);
    issue(PLAIN, 1'b1);
    chk("R5 EQ false", kill_next, 0);

    // R7: skip-with-drop drops whether or not its condition holds
    issue(16'h0020, 1'b1);
    chk("R7 drop cond false", drop_req, 1);
    issue(PLAIN, 1'b1);
    chk("R7 no kill when false", kill_next, 0);
    chk("R7 drop once", drop_req, 0);
    issue(16'h0120, 1'b1);
    chk("R7 drop cond true", drop_req, 1);
    issue(PLAIN, 1'b1);
    chk("R7 next killed", kill_next, 1);

    // R6: killed words have no effect
    issue(16'h0100, 1'b1);
    issue(16'h0100, 1'b1);
    chk("R6 killed skip", kill_next, 1);
    issue(PLAIN, 1'b1);
    chk("R6 killed skip arms nothing", kill_next, 0);
    issue(16'h0100, 1'b1);
    issue(16'h0120, 1'b1);
    chk("R6 killed drop", drop_req, 0);
    issue(16'h0100, 1'b1);
    issue(16'h0103, 1'b1);
    chk("R6 killed set strobe", set_stb, 0);
    chk("R6 killed flag word", flag_word, 0);
    issue(16'h0100, 1'b1);
    issue(16'h7105, 1'b1);
    issue(PLAIN, 1'b1);
    chk("R6 killed repeat no hold", hold_fetch, 0);

    // R9: every immediate count
    for (int n = 0; n < 32; n++) begin
      run_repeat({8'h71, 3'b000, n[4:0]}, execs);
      chk("R9 executions", execs, n + 1);
      issue(PLAIN, 1'b1);
      chk("R9 released", hold_fetch, 0);
    end
    // R9: invalid cycles inside a repeat neither hold nor count
    issue(16'h7102, 1'b1);
    issue(PLAIN, 1'b1);
    chk("R9 gap first", hold_fetch, 1);
    issue(PLAIN, 1'b0);
    chk("R9 gap idle", hold_fetch, 0);
    issue(PLAIN, 1'b1);
    chk("R9 gap second", hold_fetch, 1);
    issue(PLAIN, 1'b1);
    chk("R9 gap last", hold_fetch, 0);

    // R10: count from W
    for (int n = 0; n < 32; n += 5) begin
      w_count = n[4:0];
      run_repeat(16'h7120, execs);
      chk("R10 executions", execs, n + 1);
    end

    // R11: a skip inside a repeat is ignored
    issue(16'h7102, 1'b1);
    for (int k = 0; k < 3; k++) begin
      issue(16'h0120, 1'b1);
      chk("R11 no drop in repeat", drop_req, 0);
    end
    issue(PLAIN, 1'b1);
    chk("R11 no kill after repeat", kill_next, 0);
    // a repeat inside a repeat loads no new count
    issue(16'h7101, 1'b1);
    issue(16'h7105, 1'b1);
    issue(16'h7105, 1'b1);
    chk("R11 nested last", hold_fetch, 0);
    issue(PLAIN, 1'b1);
    chk("R11 nested no reload", hold_fetch, 0);

    // R12: reset clears a pending kill and an active repeat
    issue(16'h0100, 1'b1);
    do_reset();
    issue(PLAIN, 1'b1);
    chk("R12 kill cleared", kill_next, 0);
    issue(16'h7104, 1'b1);
    issue(PLAIN, 1'b1);
    do_reset();
    issue(PLAIN, 1'b1);
    chk("R12 repeat cleared", hold_fetch, 0);

    report();
  end
endmodule